// File: doc/BRIEF.md
# Delayed Power-Good Generator

This block produces the power-good level for a supply with several output rails. It watches three kinds of condition: a comparator flag saying the power-good input is above its threshold, one "above undervoltage" flag per rail, and a status from the on/off controller that is high only while main power is requested and no overvoltage or latched fault is present. The two comparator-derived kinds arrive asynchronously and are brought into the clock domain through two-flop synchronizers. The on/off status is already synchronous.

Power-good rises only after every condition has held without a break for a long qualification interval. It falls on the first clock edge at which any condition is seen missing. The power-good input flag also passes a short filter that delays its rising edge only, so a brief spike cannot start qualification, while a drop is never filtered. All intervals are counts of clock cycles set by parameters. The registered output drives an external open-drain stage.

Top module: `power_good_gen`

## Requirements
- R1: While reset is asserted, and after its release until a full qualification has completed, `pg_out` is 0.
- R2: `pg_out` is 1 after a clock edge exactly when the combined condition (filtered power-good input, every rail flag, `main_ok`) has been true at that edge and the QUAL_TICKS edges before it. With all inputs raised together before an edge, `pg_out` rises after the (FILT_TICKS+QUAL_TICKS+3)-th edge.
- R3: The synchronized power-good input counts as valid only once it has been high at FILT_TICKS+1 consecutive edges; a high pulse of FILT_TICKS cycles or fewer never lets `pg_out` rise.
- R4: A 0 on any bit of `rail_ok`, once through the synchronizer, clears `pg_out` at that same edge, without any filter.
- R5: A 0 on `pgi_ok` is not filtered: once through the synchronizer it clears `pg_out` at that same edge.
- R6: `main_ok` is synchronous; a 0 sampled at an edge clears `pg_out` at that edge (off request, overvoltage, latched fault).
- R7: Any loss of the combined condition during qualification restarts the count; after recovery the full QUAL_TICKS+1 edges are needed again.
- R8: `pgi_ok` and `rail_ok` pass two flops: a level sampled at edge n is first used by the qualification logic at edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all intervals are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pgi_ok | input | 1 | Asynchronous flag: power-good input above threshold |
| rail_ok | input | NUM_RAILS | Asynchronous flags: each rail above its undervoltage threshold |
| main_ok | input | 1 | Synchronous status: main power on and no fault |
| pg_out | output | 1 | Registered power-good level for the open-drain driver |

## Verification
A wrong count in the qualification or filter counter shows at the port as a rise of `pg_out` one or more cycles early or late, so the bench runs a cycle-accurate model and compares every cycle rather than only the final level. A counter that fails to clear on a broken condition shows up later, as a rise too soon after recovery, which the restart tests and random mid-count dropouts expose within one qualification interval. A missing or extra synchronizer stage moves every drop of `pg_out` by one cycle and is caught on the first loss of a rail or input.

// File: rtl/pgg_pkg.sv
package pgg_pkg;
  typedef struct packed {
    logic pgi;
    logic rails;
    logic main;
  } pgg_cond_t;
endpackage

// File: rtl/pgg_rst_sync.sv
module pgg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pgg_sync2.sv
module pgg_sync2 #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_in;
      stable_q <= meta_q;
    end
  end

  assign sync_out = stable_q;
endmodule

// File: rtl/pgg_rise_filter.sv
module pgg_rise_filter #(
  parameter int HOLD_TICKS = 73
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic level_ok
);
  localparam int CW = $clog2(HOLD_TICKS + 2);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!level_in) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != LIMIT) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // rising edge waits for the hold count, falling edge passes at once
  assign level_ok = level_in && (cnt_q == LIMIT);
endmodule

// File: rtl/pgg_qual_timer.sv
module pgg_qual_timer #(
  parameter int QUAL_TICKS = 300000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic good
);
  localparam int CW = $clog2(QUAL_TICKS + 2);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_TICKS);

  logic [CW-1:0] qcnt_q, qcnt_d;
  logic          qcnt_en;
  logic          good_q, good_d;

  always_comb begin
    qcnt_en = 1'b0;
    qcnt_d  = qcnt_q;
    if (!cond) begin
      qcnt_en = (qcnt_q != '0);
      qcnt_d  = '0;
    end else if (qcnt_q != LIMIT) begin
      qcnt_en = 1'b1;
      qcnt_d  = qcnt_q + 1'b1;
    end
    good_d = cond && (qcnt_q == LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       qcnt_q <= '0;
    else if (qcnt_en) qcnt_q <= qcnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) good_q <= 1'b0;
    else        good_q <= good_d;
  end

  assign good = good_q;
endmodule

// File: rtl/power_good_gen.sv
module power_good_gen #(
  parameter int NUM_RAILS  = 3,
  parameter int FILT_TICKS = 73,
  parameter int QUAL_TICKS = 300000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pgi_ok,
  input  logic [NUM_RAILS-1:0] rail_ok,
  input  logic                 main_ok,
  output logic                 pg_out
);
  import pgg_pkg::*;

  localparam int SYNC_W = NUM_RAILS + 1;

  logic                 rst_i_n;
  logic [SYNC_W-1:0]    sync_vec;
  logic                 pgi_s;
  logic [NUM_RAILS-1:0] rail_s;
  logic                 pgi_filt;
  pgg_cond_t            cond;
  logic                 all_ok;

  pgg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  pgg_sync2 #(.WIDTH(SYNC_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .async_in ({rail_ok, pgi_ok}),
    .sync_out (sync_vec)
  );

  assign pgi_s  = sync_vec[0];
  assign rail_s = sync_vec[SYNC_W-1:1];

  pgg_rise_filter #(.HOLD_TICKS(FILT_TICKS)) u_filt (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .level_in (pgi_s),
    .level_ok (pgi_filt)
  );

  always_comb begin
    cond.pgi   = pgi_filt;
    cond.rails = &rail_s;
    cond.main  = main_ok;
    all_ok     = cond.pgi && cond.rails && cond.main;
  end

  pgg_qual_timer #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .clk   (clk),
    .rst_n (rst_i_n),
    .cond  (all_ok),
    .good  (pg_out)
  );
endmodule

// File: rtl/power_good_gen_chk.sv
module power_good_gen_chk #(
  parameter int NUM_RAILS  = 3,
  parameter int QUAL_TICKS = 300000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pg_out,
  input logic                 main_ok,
  input logic [NUM_RAILS-1:0] rails_seen,
  input logic                 pgi_seen,
  input logic                 cond
);
  localparam int RW = $clog2(QUAL_TICKS + 3);
  localparam logic [RW-1:0] RUN_FULL = RW'(QUAL_TICKS + 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run_q <= '0;
    else if (!cond)           run_q <= '0;
    else if (run_q != RUN_FULL) run_q <= run_q + 1'b1;
  end

  assert_rail_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(&rails_seen) |=> !pg_out);

  assert_pgi_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pgi_seen |=> !pg_out);

  assert_main_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !main_ok |=> !pg_out);

  assert_rise_on_full_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == RUN_FULL) |-> pg_out);

  assert_high_needs_unbroken_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pg_out |-> (run_q == RUN_FULL));
endmodule

bind power_good_gen power_good_gen_chk #(
  .NUM_RAILS  (NUM_RAILS),
  .QUAL_TICKS (QUAL_TICKS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pg_out     (pg_out),
  .main_ok    (main_ok),
  .rails_seen (rail_s),
  .pgi_seen   (pgi_s),
  .cond       (all_ok)
);

// File: tb/tb_power_good_gen.sv
module tb_power_good_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NR   = 3;
  localparam int FILT = 3;
  localparam int QUAL = 20;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pgi_ok = 1'b0;
  logic [NR-1:0] rail_ok = '0;
  logic          main_ok = 1'b0;
  logic          pg_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit finished = 0;
  string tag = "R1";

  // reference state
  logic          mp1 = 0, mp2 = 0;
  logic [NR-1:0] mr1 = '0, mr2 = '0;
  int            run_p = 0, run_c = 0;
  logic          exp_pg = 0;

  power_good_gen #(.NUM_RAILS(NR), .FILT_TICKS(FILT), .QUAL_TICKS(QUAL)) dut (
    .clk(clk), .rst_n(rst_n), .pgi_ok(pgi_ok), .rail_ok(rail_ok),
    .main_ok(main_ok), .pg_out(pg_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic filt_passed(int run);
    return run >= FILT + 1;   // R3
  endfunction

  function automatic logic qual_passed(int run);
    return run >= QUAL + 1;   // R2
  endfunction

  task automatic model_edge();
    logic          seen_p;
    logic [NR-1:0] seen_r;
    logic          c;
    seen_p = mp2; seen_r = mr2;          // R8 two-stage delay
    mp2 = mp1; mp1 = pgi_ok;
    mr2 = mr1; mr1 = rail_ok;
    run_p = seen_p ? run_p + 1 : 0;
    c = filt_passed(run_p) && (&seen_r) && main_ok;
    run_c = c ? run_c + 1 : 0;
    exp_pg = qual_passed(run_c);
  endtask

  task automatic check(string t, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s pg_out=%0b expected %0b at cycle %0d", t, act, exp, cycles);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cycles++;
    check(tag, pg_out, exp_pg);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic set_all(logic v);
    pgi_ok = v; rail_ok = {NR{v}}; main_ok = v;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog pg_out=%0b expected end of run", pg_out);
    summary();
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_1234));
    // R1: inputs high during reset, output must stay low
    set_all(1'b1);
    repeat (4) @(negedge clk);
    check("R1", pg_out, 1'b0);
    set_all(1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    steps(6);
    check("R1", pg_out, 1'b0);

    // R2/R8: exact rise time from all inputs raised together
    tag = "R2";
    set_all(1'b1);
    n = 0;
    while (pg_out !== 1'b1 && n < 200) begin step(); n++; end
    check("R2", (n == FILT + QUAL + 3), 1'b1);
    if (n != FILT + QUAL + 3)
      $display("FAIL R2 rise after %0d edges expected %0d", n, FILT + QUAL + 3);

    // R5: one-cycle dip of pgi_ok drops the output, through sync only
    tag = "R5";
    pgi_ok = 1'b0; step(); pgi_ok = 1'b1;
    steps(2);
    check("R5", pg_out, 1'b0);

    // R3: short high pulses never qualify
    tag = "R3";
    pgi_ok = 1'b0; steps(4);
    for (int k = 0; k < 3; k++) begin
      pgi_ok = 1'b1; steps(FILT);
      pgi_ok = 1'b0; steps(2);
    end
    steps(QUAL + 4);
    check("R3", pg_out, 1'b0);
    pgi_ok = 1'b1;
    steps(FILT + QUAL + 3);
    check("R3", pg_out, 1'b1);

    // R4: each rail alone drops the output
    tag = "R4";
    for (int r = 0; r < NR; r++) begin
      rail_ok[r] = 1'b0; steps(3);
      check("R4", pg_out, 1'b0);
      rail_ok[r] = 1'b1; steps(QUAL + 4);
      check("R4", pg_out, 1'b1);
    end

    // R6: main_ok is synchronous, drop after one edge
    tag = "R6";
    main_ok = 1'b0; step();
    check("R6", pg_out, 1'b0);

    // R7: loss in mid count restarts the full delay
    tag = "R7";
    main_ok = 1'b1; steps(QUAL / 2);
    main_ok = 1'b0; step();
    main_ok = 1'b1;
    steps(QUAL);
    check("R7", pg_out, 1'b0);
    step();
    check("R7", pg_out, 1'b1);

    // random mix of dropouts over all conditions
    tag = "R7 random";
    for (int c = 0; c < 4000; c++) begin
      int sel;
      if ($urandom_range(0, 29) == 0) begin
        sel = $urandom_range(0, NR + 1);
        if (sel == 0) pgi_ok = ~pgi_ok;
        else if (sel == 1) main_ok = ~main_ok;
        else rail_ok[sel-2] = ~rail_ok[sel-2];
      end else if ($urandom_range(0, 9) == 0) begin
        set_all(1'b1);
      end
      step();
    end
    summary();
  end
endmodule